// File: doc/BRIEF.md
# Four-Phase Debug Register Target

This block is the slave side of a small debug bus that uses a return-to-zero request/acknowledge handshake. It runs in one system clock domain with a synchronous active-high reset. The master raises a request and, in the same cycle, presents an address, write data and a write flag. The target takes them in on the first cycle it sees the request. It writes the bank if the flag is set, and one clock later raises acknowledge together with the addressed register's value. Acknowledge and read data then stay frozen until the master lowers the request. The target then drops acknowledge and waits for a new rising request.

The request may be held high for an unlimited time, for example when the master's clock stops. The target never times out and never performs an access twice. Alongside the handshake, a sticky flag records two kinds of master misbehaviour: bus fields that change while a request is up, and a request that rises again in the first cycle after acknowledge fell.

Top module: `hs_target`

## Requirements
- R1: The target captures address, write data and write flag on the first clock where request is high and acknowledge is low. A write updates the bank exactly once per handshake, on that clock. Later changes to the bus fields during the same handshake leave the bank unchanged.
- R2: Once acknowledge is high, it stays high while request is high. It goes low on the first clock edge that samples request low.
- R3: While acknowledge is high, `rdata_o` is stable. For a read of a mapped address it holds the register value.
- R4: A rising request after acknowledge has fallen starts a new, separate transfer. Acknowledge never rises without a request.
- R5: Acknowledge rises on the second clock edge that samples request high: one clock after capture.
- R6: The bank holds 16 registers, selected by address bits [3:0]. An address with any bit above bit 3 set is unmapped: a read returns zero and a write changes no register.
- R7: A request held high for hundreds of cycles keeps acknowledge high and read data constant, with no re-execution.
- R8: `viol_o` goes high one clock after address, write data or write flag differ between two consecutive cycles in which request is high. It then stays high until reset.
- R9: `viol_o` goes high when request is high on the first clock after acknowledge fell. That transfer is still carried out.
- R10: Synchronous reset clears all registers, acknowledge and `viol_o`. If request is high when reset is released, no transfer runs and acknowledge stays low until request has been sampled low.
- R11: On a write transfer, `rdata_o` during acknowledge shows the addressed register after the write: the new value if the address is mapped, zero if it is not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Transfer request from master |
| addr_i | input | AW (8) | Register address |
| wdata_i | input | DW (32) | Write data |
| we_i | input | 1 | 1 = write, 0 = read |
| rdata_o | output | DW (32) | Read data, held while ack is high |
| ack_o | output | 1 | Acknowledge |
| viol_o | output | 1 | Sticky protocol violation flag |

## Verification
Two functions can land on the same clock edge: the violation monitor flagging a request that rises too soon, and the controller capturing that same request as a new transfer. The bench provokes this by raising request at the very first low-acknowledge sample after a handshake. It then judges both outcomes: the flag must be set, and the transfer must still finish with the expected read-back value. A second coincidence is the bank write and the registered read of the same register on consecutive edges. This is judged by the value returned during acknowledge of every write transfer.

// File: rtl/hstgt_pkg.sv
package hstgt_pkg;
  typedef enum logic [1:0] {
    ST_HOLDOFF = 2'd0,
    ST_IDLE    = 2'd1,
    ST_READ    = 2'd2,
    ST_ACK     = 2'd3
  } hs_state_e;
endpackage

// File: rtl/hstgt_ctrl.sv
module hstgt_ctrl
  import hstgt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic start_o,
  output logic load_o,
  output logic ack_o
);
  hs_state_e state;

  // capture happens in the idle state on the first high sample of request
  assign start_o = (state == ST_IDLE) && req_i;
  assign load_o  = (state == ST_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      // a request still high at release must first be seen low
      state <= req_i ? ST_HOLDOFF : ST_IDLE;
      ack_o <= 1'b0;
    end else begin
      unique case (state)
        ST_HOLDOFF: if (!req_i) state <= ST_IDLE;
        ST_IDLE:    if (req_i) state <= ST_READ;
        ST_READ: begin
          state <= ST_ACK;
          ack_o <= 1'b1;
        end
        ST_ACK: begin
          if (!req_i) begin
            state <= ST_IDLE;
            ack_o <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hstgt_bank.sv
module hstgt_bank #(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int NREGS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int IW = $clog2(NREGS);

  logic [DW-1:0] regs [NREGS];
  logic          wr_hit;
  logic          rd_hit;

  generate
    if (AW > IW) begin : g_decode
      assign wr_hit = (wr_addr[AW-1:IW] == '0);
      assign rd_hit = (rd_addr[AW-1:IW] == '0);
    end else begin : g_full
      assign wr_hit = 1'b1;
      assign rd_hit = 1'b1;
    end
  endgenerate

  generate
    for (genvar i = 0; i < NREGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)
          regs[i] <= '0;
        else if (wr_en && wr_hit && (wr_addr[IW-1:0] == IW'(i)))
          regs[i] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= rd_hit ? regs[rd_addr[IW-1:0]] : '0;
  end
endmodule

// File: rtl/hstgt_viol.sv
module hstgt_viol #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  input  logic          ack_i,
  output logic          viol_o
);
  logic          req_d;
  logic          ack_d;
  logic          we_d;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] wdata_d;
  logic          field_change;
  logic          early_rise;

  assign field_change = req_i && req_d &&
                        ((addr_i != addr_d) || (wdata_i != wdata_d) || (we_i != we_d));
  assign early_rise   = req_i && !ack_i && ack_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d   <= 1'b0;
      ack_d   <= 1'b0;
      we_d    <= 1'b0;
      addr_d  <= '0;
      wdata_d <= '0;
      viol_o  <= 1'b0;
    end else begin
      req_d   <= req_i;
      ack_d   <= ack_i;
      we_d    <= we_i;
      addr_d  <= addr_i;
      wdata_d <= wdata_i;
      if (field_change || early_rise) viol_o <= 1'b1;
    end
  end
endmodule

// File: rtl/hs_target.sv
module hs_target #(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int NREGS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  output logic [DW-1:0] rdata_o,
  output logic          ack_o,
  output logic          viol_o
);
  logic          start;
  logic          load;
  logic [AW-1:0] cap_addr;

  always_ff @(posedge clk) begin
    if (rst)
      cap_addr <= '0;
    else if (start)
      cap_addr <= addr_i;
  end

  hstgt_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req_i),
    .start_o (start),
    .load_o  (load),
    .ack_o   (ack_o)
  );

  hstgt_bank #(.AW(AW), .DW(DW), .NREGS(NREGS)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (start && we_i),
    .wr_addr (addr_i),
    .wr_data (wdata_i),
    .rd_en   (load),
    .rd_addr (cap_addr),
    .rd_data (rdata_o)
  );

  hstgt_viol #(.AW(AW), .DW(DW)) u_viol (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .we_i    (we_i),
    .ack_i   (ack_o),
    .viol_o  (viol_o)
  );
endmodule

// File: rtl/hstgt_chk.sv
module hstgt_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_i,
  input logic          ack_o,
  input logic [DW-1:0] rdata_o,
  input logic          viol_o
);
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ack_o && req_i) |=> ack_o);                            // R2
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
    (ack_o && !req_i) |=> !ack_o);                          // R2
  AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    (ack_o && req_i) |=> $stable(rdata_o));                 // R3
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (rst)
    (!req_i && !ack_o) |=> !ack_o);                         // R4
  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |-> $past(req_i));                         // R5
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (rst)
    viol_o |=> viol_o);                                     // R8
endmodule

bind hs_target hstgt_chk #(.DW(DW)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .req_i   (req_i),
  .ack_o   (ack_o),
  .rdata_o (rdata_o),
  .viol_o  (viol_o)
);

// File: tb/hs_target_tb_top.sv
`timescale 1ns/1ps
module hs_target_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        ack;
  logic        viol;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [16];

  always #2 clk = ~clk;

  hs_target dut_i (
    .clk(clk), .rst(rst), .req_i(req), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .rdata_o(rdata), .ack_o(ack), .viol_o(viol)
  );

  function automatic logic [31:0] exp_val(input logic [7:0] a);
    return (a < 8'd16) ? model[a[3:0]] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int cyc);
    @(negedge clk);
    rst = 1'b1;
    repeat (cyc) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 16; i++) model[i] = '0;
  endtask

  task automatic xfer(input logic [7:0] a, input bit w, input logic [31:0] d,
                      input int hold, input bit b2b);
    logic [31:0] e;
    if (!b2b) @(negedge clk);
    req = 1'b1; addr = a; we = w; wdata = d;
    if (w && a < 8'd16) model[a[3:0]] = d;
    e = exp_val(a);
    @(negedge clk);
    chk(ack == 1'b0, "R5 ack early", {31'b0, ack}, 32'h0);
    @(negedge clk);
    chk(ack == 1'b1, "R5 ack latency", {31'b0, ack}, 32'h1);
    chk(rdata == e, w ? "R11 write readback" : "R3 R6 read data", rdata, e);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(ack == 1'b1 && rdata == e, "R7 held request", rdata, e);
    end
    req = 1'b0;
    @(negedge clk);
    chk(ack == 1'b0, "R2 ack drop", {31'b0, ack}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed_1234);
    for (int i = 0; i < 16; i++) model[i] = '0;
    do_reset(3);
    @(negedge clk);
    chk(ack == 1'b0 && viol == 1'b0, "R10 reset state", {30'b0, ack, viol}, 32'h0);
    chk(rdata == 32'h0, "R10 reset rdata", rdata, 32'h0);

    // directed: write then read, unmapped alias
    xfer(8'd5, 1'b1, 32'hA5A5_0001, 0, 1'b0);
    xfer(8'd5, 1'b0, 32'h0, 2, 1'b0);
    xfer(8'h15, 1'b1, 32'hDEAD_BEEF, 0, 1'b0);   // R6 ignored write
    xfer(8'd5, 1'b0, 32'h0, 0, 1'b0);            // R6 alias must not change
    xfer(8'h15, 1'b0, 32'h0, 0, 1'b0);           // R6 unmapped reads zero
    chk(viol == 1'b0, "R8 no false flag", {31'b0, viol}, 32'h0);

    // R7: very long hold
    xfer(8'd5, 1'b0, 32'h0, 300, 1'b0);

    // R9 / R4: back-to-back rise right after ack fell
    xfer(8'd7, 1'b1, 32'h1111_2222, 0, 1'b0);
    xfer(8'd7, 1'b0, 32'h0, 0, 1'b1);
    chk(viol == 1'b1, "R9 early rise flagged", {31'b0, viol}, 32'h1);

    // R10: reset clears flag and bank
    do_reset(2);
    @(negedge clk);
    chk(viol == 1'b0, "R10 flag cleared", {31'b0, viol}, 32'h0);
    xfer(8'd7, 1'b0, 32'h0, 0, 1'b0);

    // R1 / R8: field change mid-handshake
    @(negedge clk);
    req = 1'b1; addr = 8'd9; we = 1'b1; wdata = 32'hCAFE_0009;
    model[9] = 32'hCAFE_0009;
    repeat (2) @(negedge clk);
    wdata = 32'h0BAD_0BAD;
    @(negedge clk);
    chk(viol == 1'b1, "R8 field change flagged", {31'b0, viol}, 32'h1);
    chk(ack == 1'b1, "R7 ack kept", {31'b0, ack}, 32'h1);
    req = 1'b0;
    @(negedge clk);
    xfer(8'd9, 1'b0, 32'h0, 0, 1'b0);            // R1 single write
    chk(viol == 1'b1, "R8 sticky", {31'b0, viol}, 32'h1);

    // R10: request high across reset release
    @(negedge clk);
    rst = 1'b1; req = 1'b1; addr = 8'd3; we = 1'b1; wdata = 32'h3333_3333;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 16; i++) model[i] = '0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(ack == 1'b0, "R10 holdoff", {31'b0, ack}, 32'h0);
    end
    req = 1'b0;
    @(negedge clk);
    xfer(8'd3, 1'b0, 32'h0, 0, 1'b0);
    chk(viol == 1'b0, "R10 holdoff no flag", {31'b0, viol}, 32'h0);

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [7:0] a;
      a = 8'($urandom_range(0, 19));
      xfer(a, 1'($urandom_range(0, 1)), $urandom(), $urandom_range(0, 5), 1'b0);
    end
    chk(viol == 1'b0, "R8 random no flag", {31'b0, viol}, 32'h0);
    for (int i = 0; i < 16; i++) xfer(8'(i), 1'b0, 32'h0, 0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule